// File: doc/BRIEF.md
# Four-Channel Shadowed DAC Register Block

This block is the register front end for four 12-bit digital-to-analog converter channels. A 16-bit register bus writes a mode word, a shared control word that carries each channel's polarity and gain selection, and one data word per channel. Control and data writes land in staging registers. A read of the control address commits the staged control word to the polarity and gain outputs. A read of the data-update address copies all four staged data words to the code outputs in one cycle, so every channel steps at the same instant.

A small mode state machine decides how data writes behave. Reset puts it in `MODE_OFF`, where every code output is held at zero. From any state, a write to the mode address moves it to `MODE_OFF` (enable bit clear), `MODE_DIRECT` (enable set, buffered clear) or `MODE_BUFFERED` (both set). In `MODE_DIRECT` a data write reaches its output on the next cycle without an update read. In `MODE_BUFFERED` a data write waits for the update read. With no mode write the state does not change. Reads are strobes only: the bus has no read data path.

Top module: `dac_shadow_regs`

## Requirements
- R1: After reset every code output, every polarity output and every gain output is zero, and the mode state is `MODE_OFF`.
- R2: A write to word address 0 sets the mode. Bit 1 is enable and bit 0 is buffered. Enable clear gives `MODE_OFF`, enable set with buffered clear gives `MODE_DIRECT`, and both set give `MODE_BUFFERED`. The new mode takes effect from the next cycle.
- R3: In `MODE_OFF` all code outputs read zero. Staging and committing still work, and the active words appear as soon as the block is enabled again.
- R4: The data word of channel n (n = 0..3) is at word address 4+n. Only bits 11:0 of a data write are kept.
- R5: In `MODE_BUFFERED` a data write does not change any code output. A read of word address 2 copies all four staged words to the code outputs together on the next cycle.
- R6: In `MODE_DIRECT` a data write to channel n shows on that channel's code output on the next cycle.
- R7: The control word is at word address 1. Bit 7-n is the polarity of channel n (1 means bipolar), bit 11-n is the gain of channel n, and all other bits are ignored. A read of address 1 commits the staged word on the next cycle.
- R8: A control write does not change the polarity or gain outputs until the commit read.
- R9: Writes and reads at word addresses 3 and 8 to 15, and writes to address 2, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used only to trigger commits |
| bus_wdata | input | 16 | Write data |
| dac_code_o | output | 48 | Channel n code in bits 12n+11:12n |
| dac_bipolar_o | output | 4 | Active polarity per channel, 1 = bipolar |
| dac_gain_o | output | 4 | Active gain selection per channel |

## Verification
A wrong mode state shows at the code outputs one cycle after the next data write or mode change: the outputs stay at zero, or a staged word leaks out early or late. A staged word that is wrong stays hidden until the next update read and then appears on every affected channel at once. A reference model that tracks the staged and active values separately is compared every cycle, so a fault is reported within one cycle of becoming visible. A control bit routed to the wrong channel shows on the first commit read that follows a control write with a mix of ones and zeros.

// File: rtl/dac_shadow_pkg.sv
package dac_shadow_pkg;
    typedef enum logic [1:0] {
        MODE_OFF      = 2'd0,
        MODE_DIRECT   = 2'd1,
        MODE_BUFFERED = 2'd2
    } dac_mode_e;

    localparam int unsigned ADR_MODE  = 0;
    localparam int unsigned ADR_CTRL  = 1;
    localparam int unsigned ADR_DUPD  = 2;
    localparam int unsigned ADR_DATA0 = 4;

    localparam int unsigned MODE_EN_BIT  = 1;
    localparam int unsigned MODE_BUF_BIT = 0;
    localparam int unsigned POL_TOP      = 7;
    localparam int unsigned GAIN_TOP     = 11;
endpackage

// File: rtl/dac_mode_fsm.sv
module dac_mode_fsm
    import dac_shadow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic en_bit,
    input  logic buf_bit,
    output logic codes_on,
    output logic pass_through
);
    dac_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_OFF, MODE_DIRECT, MODE_BUFFERED: begin
                if (mode_wr) begin
                    if (!en_bit)      state_d = MODE_OFF;
                    else if (buf_bit) state_d = MODE_BUFFERED;
                    else              state_d = MODE_DIRECT;
                end
            end
            default: state_d = MODE_OFF;
        endcase
    end

    always_comb begin
        codes_on     = 1'b0;
        pass_through = 1'b0;
        unique case (state_q)
            MODE_OFF:      ;
            MODE_DIRECT:   begin codes_on = 1'b1; pass_through = 1'b1; end
            MODE_BUFFERED: codes_on = 1'b1;
            default:       ;
        endcase
    end
endmodule

// File: rtl/dac_ctrl_shadow.sv
module dac_ctrl_shadow #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stage_wr,
    input  logic           commit,
    input  logic [NCH-1:0] pol_in,
    input  logic [NCH-1:0] gain_in,
    output logic [NCH-1:0] pol_out,
    output logic [NCH-1:0] gain_out
);
    logic [NCH-1:0] pol_stage, gain_stage;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_stage  <= '0;
            gain_stage <= '0;
            pol_out    <= '0;
            gain_out   <= '0;
        end else begin
            if (stage_wr) begin
                pol_stage  <= pol_in;
                gain_stage <= gain_in;
            end
            if (commit) begin
                pol_out  <= pol_stage;
                gain_out <= gain_stage;
            end
        end
    end
endmodule

// File: rtl/dac_data_chan.sv
module dac_data_chan #(
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              direct,
    input  logic              commit,
    input  logic [CODE_W-1:0] wdata,
    output logic [CODE_W-1:0] active
);
    logic [CODE_W-1:0] staged;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
            active <= '0;
        end else begin
            if (wr) staged <= wdata;
            if (wr && direct) active <= wdata;
            else if (commit)  active <= staged;
        end
    end
endmodule

// File: rtl/dac_shadow_regs.sv
module dac_shadow_regs
    import dac_shadow_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BUS_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [NCH*CODE_W-1:0] dac_code_o,
    output logic [NCH-1:0]        dac_bipolar_o,
    output logic [NCH-1:0]        dac_gain_o
);
    logic hit_mode, hit_ctrl, hit_dupd;
    logic codes_on, pass_through;
    logic [NCH-1:0] pol_field, gain_field;
    logic [NCH*CODE_W-1:0] active_flat;
    logic unused_wbits;

    assign unused_wbits = ^bus_wdata;
    assign hit_mode = (bus_addr == ADDR_W'(ADR_MODE));
    assign hit_ctrl = (bus_addr == ADDR_W'(ADR_CTRL));
    assign hit_dupd = (bus_addr == ADDR_W'(ADR_DUPD));

    dac_mode_fsm u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr      (bus_wr && hit_mode),
        .en_bit       (bus_wdata[MODE_EN_BIT]),
        .buf_bit      (bus_wdata[MODE_BUF_BIT]),
        .codes_on     (codes_on),
        .pass_through (pass_through)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_field
        assign pol_field[n]  = bus_wdata[POL_TOP - n];
        assign gain_field[n] = bus_wdata[GAIN_TOP - n];
    end

    dac_ctrl_shadow #(.NCH(NCH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_wr (bus_wr && hit_ctrl),
        .commit   (bus_rd && hit_ctrl),
        .pol_in   (pol_field),
        .gain_in  (gain_field),
        .pol_out  (dac_bipolar_o),
        .gain_out (dac_gain_o)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        logic hit_data;
        assign hit_data = (bus_addr == ADDR_W'(ADR_DATA0 + n));

        dac_data_chan #(.CODE_W(CODE_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (bus_wr && hit_data),
            .direct (pass_through),
            .commit (bus_rd && hit_dupd),
            .wdata  (bus_wdata[CODE_W-1:0]),
            .active (active_flat[n*CODE_W +: CODE_W])
        );

        assign dac_code_o[n*CODE_W +: CODE_W] =
            codes_on ? active_flat[n*CODE_W +: CODE_W] : '0;
    end
endmodule

// File: rtl/dac_shadow_regs_chk.sv
module dac_shadow_regs_chk
    import dac_shadow_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BUS_W  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [BUS_W-1:0]      bus_wdata,
    input logic [NCH*CODE_W-1:0] dac_code_o,
    input logic [NCH-1:0]        dac_bipolar_o,
    input logic [NCH-1:0]        dac_gain_o
);
    logic trk_en, trk_buf;
    logic a_mode, a_ctrl, a_dupd, a_data0, a_unmapped;

    assign a_mode     = (bus_addr == ADDR_W'(ADR_MODE));
    assign a_ctrl     = (bus_addr == ADDR_W'(ADR_CTRL));
    assign a_dupd     = (bus_addr == ADDR_W'(ADR_DUPD));
    assign a_data0    = (bus_addr == ADDR_W'(ADR_DATA0));
    assign a_unmapped = (bus_addr == ADDR_W'(3)) ||
                        (int'(bus_addr) >= int'(ADR_DATA0 + NCH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_en  <= 1'b0;
            trk_buf <= 1'b0;
        end else if (bus_wr && a_mode) begin
            trk_en  <= bus_wdata[MODE_EN_BIT];
            trk_buf <= bus_wdata[MODE_BUF_BIT];
        end
    end

    // R3
    p_off_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !trk_en |-> (dac_code_o == '0));

    // R5
    p_buf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_en && trk_buf && !(bus_rd && a_dupd) && !(bus_wr && a_mode))
        |=> $stable(dac_code_o));

    // R6
    p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_en && !trk_buf && bus_wr && a_data0)
        |=> (dac_code_o[CODE_W-1:0] == $past(bus_wdata[CODE_W-1:0])));

    // R8
    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && a_ctrl) |=> ($stable(dac_bipolar_o) && $stable(dac_gain_o)));

    // R9
    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && a_unmapped)
        |=> ($stable(dac_code_o) && $stable(dac_bipolar_o) && $stable(dac_gain_o)));
endmodule

bind dac_shadow_regs dac_shadow_regs_chk #(
    .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_wdata     (bus_wdata),
    .dac_code_o    (dac_code_o),
    .dac_bipolar_o (dac_bipolar_o),
    .dac_gain_o    (dac_gain_o)
);

// File: tb/dac_shadow_regs_tb.sv
module dac_shadow_regs_tb;
    localparam int NCH = 4;
    localparam int CW  = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [15:0]      bus_wdata = '0;
    logic [NCH*CW-1:0] dac_code_o;
    logic [NCH-1:0]   dac_bipolar_o;
    logic [NCH-1:0]   dac_gain_o;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    bit m_en = 0, m_buf = 0;
    int m_sd[NCH];
    int m_ad[NCH];
    int m_sc = 0, m_ac = 0;

    always #2 clk = ~clk;

    dac_shadow_regs u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .dac_code_o    (dac_code_o),
        .dac_bipolar_o (dac_bipolar_o),
        .dac_gain_o    (dac_gain_o)
    );

    task automatic compare(string tag);
        logic [NCH*CW-1:0] e_code;
        logic [NCH-1:0] e_bip, e_gain;
        for (int n = 0; n < NCH; n++) begin
            e_code[n*CW +: CW] = m_en ? CW'(m_ad[n]) : '0;
            e_bip[n]  = m_ac[7-n];
            e_gain[n] = m_ac[11-n];
        end
        n_checks++;
        if (dac_code_o !== e_code || dac_bipolar_o !== e_bip || dac_gain_o !== e_gain) begin
            n_fail++;
            $display("FAIL %s: code=%h bip=%b gain=%b expected code=%h bip=%b gain=%b",
                     tag, dac_code_o, dac_bipolar_o, dac_gain_o, e_code, e_bip, e_gain);
        end
    endtask

    // one bus cycle: drive at negedge, model update after posedge, compare
    task automatic op(bit wr, bit rd, int addr, int wd, string tag);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = 4'(addr); bus_wdata = 16'(wd);
        @(posedge clk);
        #1;
        if (wr) begin
            if (addr == 0) begin m_en = wd[1]; m_buf = wd[0]; end
            else if (addr == 1) m_sc = wd & 'h0FF0;
            else if (addr >= 4 && addr < 4 + NCH) begin
                m_sd[addr-4] = wd & 'hFFF;
                if (m_en && !m_buf) m_ad[addr-4] = wd & 'hFFF;
            end
        end
        if (rd) begin
            if (addr == 1) m_ac = m_sc;
            else if (addr == 2) for (int n = 0; n < NCH; n++) m_ad[n] = m_sd[n];
        end
        compare(tag);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic idle(string tag);
        op(0, 0, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int n = 0; n < NCH; n++) begin m_sd[n] = 0; m_ad[n] = 0; end
        repeat (3) @(posedge clk);
        #1 compare("R1 reset");
        @(negedge clk); rst_n = 1'b1;
        idle("R1 after reset");

        // buffered mode
        op(1, 0, 0, 'h0003, "R2 mode buffered");
        op(1, 0, 4, 'hF123, "R4 R5 stage ch0 upper bits dropped");
        op(1, 0, 5, 'h0456, "R5 stage ch1");
        op(1, 0, 6, 'h0FFF, "R5 stage ch2 max");
        op(1, 0, 7, 'hA000, "R4 stage ch3 only upper bits");
        idle("R5 still held");
        op(0, 1, 2, 0, "R5 update all");
        op(1, 0, 5, 'h0001, "R5 new ch1 held");
        idle("R5 held");
        op(0, 1, 2, 0, "R5 second update");

        // control
        op(1, 0, 1, 'h0A50, "R8 control staged");
        idle("R8 control held");
        op(0, 1, 1, 0, "R7 control commit");
        op(1, 0, 1, 'hF50F, "R8 control staged other bits");
        op(0, 1, 1, 0, "R7 control commit ignores bits");
        op(1, 0, 1, 'h0FF0, "R8 all set staged");
        op(0, 1, 1, 0, "R7 all set");

        // direct mode
        op(1, 0, 0, 'h0002, "R2 mode direct");
        op(1, 0, 6, 'h0ABC, "R6 direct ch2");
        op(1, 0, 4, 'h0000, "R6 direct ch0 zero");
        op(1, 0, 7, 'h1FFF, "R6 R4 direct ch3");

        // off mode
        op(1, 0, 0, 'h0001, "R3 mode off");
        op(1, 0, 7, 'h0321, "R3 stage while off");
        op(0, 1, 2, 0, "R3 update while off");
        op(1, 0, 0, 'h0003, "R3 reenable shows active");
        op(1, 0, 0, 'h0000, "R3 off again");
        op(1, 0, 0, 'h0002, "R2 back to direct");

        // unmapped accesses
        op(1, 0, 3, 'hFFFF, "R9 write addr 3");
        op(0, 1, 3, 0, "R9 read addr 3");
        op(1, 0, 8, 'hFFFF, "R9 write addr 8");
        op(1, 0, 15, 'h0FFF, "R9 write addr 15");
        op(0, 1, 12, 0, "R9 read addr 12");
        op(1, 0, 2, 'h0FFF, "R9 write update addr");
        op(1, 0, 0, 'h0003, "R2 buffered again");
        op(1, 0, 2, 'hFFFF, "R9 write update addr buffered");
        op(0, 1, 2, 0, "R5 update after ignored writes");
        idle("R9 final");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule